// File: doc/BRIEF.md
# Packed BCD Decimal Adjust Unit

This unit repairs the accumulator after two packed-BCD bytes have been added in plain binary, so that it again holds two valid decimal digits. It takes the 8-bit sum, the half-carry (AC) and the carry (CY) from that addition. It returns the corrected byte and the updated carry. The whole adjustment finishes in one step. The overflow flag is not an input or an output, so the unit never changes it. Only addition results are handled.

The correction runs in two stages. The low stage looks at the low digit and the half-carry. The high stage looks at the high digit and at the carry as it stands after the low stage. A carry out of either stage sets the carry. The adjustment never clears it. In the default registered form, a one-cycle `start_i` strobe latches the inputs. On the following edge the result appears and `done_o` pulses for one clock.

Top module: `bcd_adjust_unit`

## Requirements
- R1: When the low digit (bits 3..0) is above 9, or AC is 1, the low stage adds 06h to the whole byte.
- R2: A carry out of bit 7 from the low stage sets the outgoing CY.
- R3: After the low stage, if CY (incoming or from R2) is 1, or the high digit (bits 7..4) is above 9, the high stage adds 60h. Its carry out of bit 7 sets CY.
- R4: CY is sticky: an incoming CY of 1 always gives an outgoing CY of 1.
- R5: The net change to the byte is exactly one of 00h, 06h, 60h or 66h. A byte with two valid digits, AC = 0 and CY = 0 comes back unchanged with CY = 0.
- R6: Input C9h with AC = 0 and CY = 0 yields 29h with CY = 1.
- R7: A start strobe latches the result. `done_o` is high for exactly the clock after each strobe. Without a strobe, `acc_o` and `cy_o` hold.
- R8: After reset, `acc_o` = 00h, `cy_o` = 0 and `done_o` = 0.
- R9: Take two-digit decimal values a and b (0..99) and an incoming carry c. Add them in binary as packed BCD, with AC and CY from that add, then adjust. The result is (a+b+c) mod 100 in packed BCD, and CY = 1 exactly when a+b+c ≥ 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Strobe that latches a new adjustment |
| acc_i | input | 8 | Binary sum to correct |
| ac_i | input | 1 | Half-carry from the addition |
| cy_i | input | 1 | Carry from the addition |
| acc_o | output | 8 | Adjusted byte |
| cy_o | output | 1 | Updated carry |
| done_o | output | 1 | One-clock result-valid pulse |

## Verification
The assertions assume `acc_i`, `ac_i` and `cy_i` are stable and known in any cycle where `start_i` is high. They also assume `start_i` itself is never X once reset is released. The correction-set and stickiness properties hold for any byte. The claim that digits come back valid holds only when the inputs come from a real BCD addition. The exhaustive stimulus therefore builds each input triple from an actual packed-BCD add of two legal operands plus a carry. The directed vectors, which include non-BCD bytes, are checked against hand-worked expected values, not against digit validity.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;
  localparam int DIG_W   = 4;
  localparam int DIG_MAX = 9;

  typedef enum logic [1:0] {
    CORR_NONE = 2'b00,
    CORR_LO   = 2'b01,
    CORR_HI   = 2'b10,
    CORR_BOTH = 2'b11
  } corr_e;
endpackage

// File: rtl/bcd_lo_fix.sv
module bcd_lo_fix #(
  parameter int NIB_W   = bcd_adj_pkg::DIG_W,
  parameter int DIG_MAX = bcd_adj_pkg::DIG_MAX
) (
  input  logic [2*NIB_W-1:0] acc_i,
  input  logic               ac_i,
  input  logic               cy_i,
  output logic [2*NIB_W-1:0] sum_o,
  output logic               cy_o,
  output logic               carry_o,
  output logic               hit_o
);
  localparam int BYTE_W = 2*NIB_W;
  localparam logic [BYTE_W-1:0] LO_ADD = BYTE_W'(6);
  localparam logic [NIB_W-1:0]  LIMIT  = NIB_W'(DIG_MAX);

  logic [BYTE_W:0] wide;

  always_comb begin
    hit_o   = (acc_i[NIB_W-1:0] > LIMIT) || ac_i;
    wide    = {1'b0, acc_i} + {1'b0, (hit_o ? LO_ADD : '0)};
    sum_o   = wide[BYTE_W-1:0];
    carry_o = wide[BYTE_W];
    cy_o    = cy_i | carry_o;  // sticky
  end
endmodule

// File: rtl/bcd_hi_fix.sv
module bcd_hi_fix #(
  parameter int NIB_W   = bcd_adj_pkg::DIG_W,
  parameter int DIG_MAX = bcd_adj_pkg::DIG_MAX
) (
  input  logic [2*NIB_W-1:0] acc_i,
  input  logic               cy_i,
  output logic [2*NIB_W-1:0] sum_o,
  output logic               cy_o,
  output logic               hit_o
);
  localparam int BYTE_W = 2*NIB_W;
  localparam logic [BYTE_W-1:0] HI_ADD = BYTE_W'(6) << NIB_W;
  localparam logic [NIB_W-1:0]  LIMIT  = NIB_W'(DIG_MAX);

  logic [BYTE_W:0] wide;

  always_comb begin
    hit_o = cy_i || (acc_i[BYTE_W-1:NIB_W] > LIMIT);
    wide  = {1'b0, acc_i} + {1'b0, (hit_o ? HI_ADD : '0)};
    sum_o = wide[BYTE_W-1:0];
    cy_o  = cy_i | wide[BYTE_W];
  end
endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit #(
  parameter int NIB_W   = bcd_adj_pkg::DIG_W,
  parameter int DIG_MAX = bcd_adj_pkg::DIG_MAX,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [7:0]   acc_i,
  input  logic         ac_i,
  input  logic         cy_i,
  output logic [7:0]   acc_o,
  output logic         cy_o,
  output logic         done_o
);
  import bcd_adj_pkg::*;
  localparam int BYTE_W = 2*NIB_W;
  localparam logic [BYTE_W-1:0] ADD_LO = BYTE_W'(6);
  localparam logic [BYTE_W-1:0] ADD_HI = BYTE_W'(6) << NIB_W;

  logic [BYTE_W-1:0] mid_sum, fin_sum;
  logic              mid_cy, mid_carry, fin_cy, lo_hit, hi_hit;
  corr_e             corr_kind;

  bcd_lo_fix #(.NIB_W(NIB_W), .DIG_MAX(DIG_MAX)) u_lo (
    .acc_i(acc_i), .ac_i(ac_i), .cy_i(cy_i),
    .sum_o(mid_sum), .cy_o(mid_cy), .carry_o(mid_carry), .hit_o(lo_hit)
  );

  bcd_hi_fix #(.NIB_W(NIB_W), .DIG_MAX(DIG_MAX)) u_hi (
    .acc_i(mid_sum), .cy_i(mid_cy),
    .sum_o(fin_sum), .cy_o(fin_cy), .hit_o(hi_hit)
  );

  assign corr_kind = corr_e'({hi_hit, lo_hit});

  generate
    if (REG_OUT) begin : g_reg
      logic [BYTE_W-1:0] acc_q;
      logic              cy_q, done_q;
      corr_e             kind_q;
      logic              lo_carry_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          acc_q      <= '0;
          cy_q       <= 1'b0;
          done_q     <= 1'b0;
          kind_q     <= CORR_NONE;
          lo_carry_q <= 1'b0;
        end else begin
          done_q <= start_i;
          if (start_i) begin
            acc_q      <= fin_sum;
            cy_q       <= fin_cy;
            kind_q     <= corr_kind;
            lo_carry_q <= mid_carry;
          end
        end
      end

      assign acc_o  = acc_q;
      assign cy_o   = cy_q;
      assign done_o = done_q;

      // R4: incoming carry survives
      assert_sticky_cy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && cy_i) |=> cy_o);

      // R7: done follows each strobe for one clock; result holds otherwise
      assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> done_o);
      assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_i |=> (!done_o && $stable(acc_o) && $stable(cy_o)));

      // R5: applied delta matches the stage decisions
      assert_delta_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> ((acc_o - $past(acc_i)) ==
                     ((kind_q[0] ? ADD_LO : '0) + (kind_q[1] ? ADD_HI : '0))));

      // R2/R3: low-stage carry forces the high stage and sets CY
      assert_lo_carry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && lo_carry_q) |-> (kind_q == CORR_BOTH && cy_o));
    end else begin : g_comb
      assign acc_o  = fin_sum;
      assign cy_o   = fin_cy;
      assign done_o = start_i;
    end
  endgenerate
endmodule

// File: tb/tb_bcd_adjust_unit.sv
module tb_bcd_adjust_unit;
  typedef struct {
    logic [7:0] acc;
    logic       cy;
    string      req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] acc_in = '0;
  logic       ac_in = 1'b0, cy_in = 1'b0;
  logic [7:0] acc_out;
  logic       cy_out, done;

  int n_vec = 0, n_bad = 0;
  bit finished = 0;
  exp_t sb[$];

  always #4 clk = ~clk;  // 125 MHz

  bcd_adjust_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .acc_i(acc_in), .ac_i(ac_in), .cy_i(cy_in),
    .acc_o(acc_out), .cy_o(cy_out), .done_o(done)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: called at negedge
  task automatic drive(input logic [7:0] a, input logic ac, input logic cy,
                       input logic [7:0] ea, input logic ecy, input string req);
    exp_t e;
    acc_in = a; ac_in = ac; cy_in = cy; start = 1'b1;
    e.acc = ea; e.cy = ecy; e.req = req;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) check("R7 spurious done", {1'b1, 8'h00}, 9'h000);
      else begin
        exp_t e;
        e = sb.pop_front();
        check(e.req, {cy_out, acc_out}, {e.cy, e.acc});
      end
    end
  end

  function automatic logic [7:0] to_bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  initial begin
    #2000000;
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] held_acc;
    logic       held_cy;
    repeat (3) @(negedge clk);
    check("R8 reset", {done, cy_out, acc_out}, 10'h000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 idle", {done, cy_out, acc_out}, 10'h000);

    drive(8'h45, 0, 0, 8'h45, 0, "R5 valid digits untouched");
    drive(8'h4B, 0, 0, 8'h51, 0, "R1 low digit above nine");
    drive(8'h42, 1, 0, 8'h48, 0, "R1 half carry");
    drive(8'hFA, 0, 0, 8'h60, 1, "R2 low stage carry out");
    drive(8'hA2, 0, 0, 8'h02, 1, "R3 high digit above nine");
    drive(8'h12, 0, 1, 8'h72, 1, "R3 incoming carry");
    drive(8'h9A, 0, 0, 8'h00, 1, "R3 high after low ripple");
    drive(8'h00, 0, 1, 8'h60, 1, "R4 sticky carry");
    drive(8'h99, 1, 1, 8'hFF, 1, "R5 both corrections");
    drive(8'hC9, 0, 0, 8'h29, 1, "R6 30+99 case");
    @(negedge clk);
    @(negedge clk);
    held_acc = acc_out; held_cy = cy_out;
    check("R7 done low when idle", {8'h00, done}, 9'h000);
    acc_in = 8'hAA; ac_in = 1; cy_in = 0;
    repeat (3) @(negedge clk);
    check("R7 hold without strobe", {cy_out, acc_out}, {held_cy, held_acc});

    for (int a = 0; a < 100; a++)
      for (int b = 0; b < 100; b++)
        for (int c = 0; c < 2; c++) begin
          logic [7:0] pa, pb, bin;
          logic ac, cy;
          int   dec;
          pa  = to_bcd(a); pb = to_bcd(b);
          {cy, bin} = 9'(pa) + 9'(pb) + 9'(c);
          ac  = ((5'(pa[3:0]) + 5'(pb[3:0]) + 5'(c)) > 5'd15);
          dec = a + b + c;
          drive(bin, ac, cy, to_bcd(dec % 100), dec >= 100, "R9 decimal sum");
        end
    repeat (3) @(negedge clk);
    check("R9 scoreboard drained", 9'(sb.size()), 9'd0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule